// File: doc/BRIEF.md
# Doorbell-Started Ring Fetch Engine

This block is the hardware reader of a command or transfer ring that sits in shared memory as a sequence of 16-byte entries. It holds a dequeue byte address and a one-bit consumer cycle state. Software places work in the ring and writes the doorbell. The engine then reads entries one at a time from its dequeue address. Each entry whose cycle bit equals the consumer cycle state belongs to the engine: it is forwarded on an output stream together with its own byte address, and the dequeue address moves on by 16 bytes. The first entry whose cycle bit differs from the state ends the run. The engine goes back to idle and keeps its address and cycle state, so the next doorbell resumes at the entry that stopped it.

A link entry is never forwarded. It sends the fetch to the address held in its address field, and when its toggle flag is set it inverts the consumer cycle state. This lets the ring wrap, so that on the next pass entries marked 0 count as owned. A doorbell that arrives while a run is in progress is remembered. Once the run stops, the engine checks the current entry one more time. Memory is read over a simple request pulse and response strobe, with at most one read in flight.

The engine moves through three states. `ST_IDLE` is left for `ST_REQ` on a doorbell. `ST_REQ` issues one read and always moves to `ST_WAIT`. `ST_WAIT` holds until the response arrives. From there it returns to `ST_REQ` when the entry is owned (forwarded or followed as a link). When the entry is not owned, it goes to `ST_REQ` if a doorbell is pending or arriving, and otherwise to `ST_IDLE`.

Top module: `ring_fetch_engine`

## Requirements
- R1: After reset, `mem_rd_req` and `ent_valid` are 0, the dequeue address is `RING_BASE` and the consumer cycle state is 1.
- R2: No read is issued before a doorbell. A doorbell seen in idle starts a read of the current dequeue address.
- R3: An entry is owned when its cycle bit (bit 96, the lowest bit of the flags word in bits 127:96) equals the consumer cycle state. An owned non-link entry is presented on `ent_data` with `ent_valid` high for one cycle. This happens in the cycle after its response, with `ent_addr` equal to the address it was read from. The next read is at that address plus 16.
- R4: A response that is not owned ends the run with nothing forwarded. The dequeue address and cycle state are kept, and the next doorbell reads the same address again.
- R5: An owned entry whose type field (bits 111:106, flags bits 15:10) equals 6 is a link. It is not forwarded, and the next read is at its address field (bits 63:0) with the lowest four bits cleared.
- R6: An owned link entry with its toggle flag (bit 97, flags bit 1) set inverts the consumer cycle state. With the flag clear, the state is kept. The toggle flag has no effect on non-link entries.
- R7: Forwarded entries carry all 128 bits unchanged: address field in bits 63:0, status in bits 95:64, flags in bits 127:96.
- R8: Any number of doorbells during a run collapse into one pending request. When the run stops, the engine re-reads the current entry once more instead of going idle.
- R9: `mem_rd_req` is a one-cycle pulse, and no new read is issued while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| doorbell | input | 1 | One-cycle pulse: work has been placed in the ring |
| mem_rd_req | output | 1 | One-cycle read request for one entry |
| mem_rd_addr | output | ADDR_W | Byte address of the requested entry |
| mem_rd_rsp_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 128 | Entry returned by memory |
| ent_valid | output | 1 | Forwarded entry strobe |
| ent_addr | output | ADDR_W | Byte address of the forwarded entry |
| ent_data | output | 128 | Forwarded entry contents |

## Verification
Random rings of 4 to 12 entries, closed by a toggling link, are filled in bursts of zero up to the full free space. The bursts cross the link repeatedly, which separates a correct cycle flip from a missing or doubled one, and also shows whether stale entries from the previous pass are skipped. Random toggle flags on ordinary entries expose a design that flips the state on the wrong entry type. A directed link without toggle, whose target has low bits set, checks both the jump address and the preserved cycle. A read stream is counted while doorbells are rung during a slow read. This shows whether the pending doorbell is kept, whether it is collapsed, and whether an empty ring is read exactly once and then resumed at the same address.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
    localparam int ENT_W      = 128;
    localparam int ENT_BYTES  = 16;
    localparam int FLAGS_LSB  = 96;
    localparam int CYC_BIT    = FLAGS_LSB + 0;
    localparam int TOG_BIT    = FLAGS_LSB + 1;
    localparam int TYPE_LSB   = FLAGS_LSB + 10;
    localparam int TYPE_W     = 6;
    localparam logic [TYPE_W-1:0] LINK_CODE = 6'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/ring_entry_decode.sv
module ring_entry_decode
    import ring_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                cyc_bit,
    input  logic                tog_bit,
    input  logic [TYPE_W-1:0]   type_f,
    input  logic [ADDR_W-1:0]   link_field,
    input  logic                cyc_state,
    output logic                owned,
    output logic                is_link,
    output logic                flip_req,
    output logic [ADDR_W-1:0]   link_target
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(ENT_BYTES - 1);

    always_comb begin
        owned       = (cyc_bit == cyc_state);
        is_link     = (type_f == LINK_CODE);
        flip_req    = is_link && tog_bit;
        link_target = link_field & ALIGN_MASK;
    end
endmodule

// File: rtl/ring_deq_ptr.sv
module ring_deq_ptr
    import ring_fetch_pkg::*;
#(
    parameter int                ADDR_W    = 64,
    parameter logic [ADDR_W-1:0] RING_BASE = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              jump,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic              flip,
    output logic [ADDR_W-1:0] deq_addr,
    output logic              cyc_state
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ENT_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deq_addr  <= RING_BASE;
            cyc_state <= 1'b1;
        end else begin
            if (jump) begin
                deq_addr <= jump_addr;
            end else if (step) begin
                deq_addr <= deq_addr + STRIDE;
            end
            if (flip) begin
                cyc_state <= ~cyc_state;
            end
        end
    end
endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
    import ring_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell,
    input  logic              rsp_valid,
    input  logic [ENT_W-1:0]  rsp_entry,
    input  logic              owned,
    input  logic              is_link,
    input  logic              flip_req,
    input  logic [ADDR_W-1:0] deq_addr,
    output logic              rd_req,
    output logic              step,
    output logic              jump,
    output logic              flip,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [ENT_W-1:0]  ent_data
);
    fetch_state_t state, state_nx;
    logic         db_pend, db_pend_nx;
    logic         resp_here, stop_here;

    always_comb begin
        resp_here = (state == ST_WAIT) && rsp_valid;
        stop_here = resp_here && !owned;
    end

    // next state and doorbell latch
    always_comb begin
        state_nx   = state;
        db_pend_nx = db_pend;
        if (stop_here) begin
            db_pend_nx = 1'b0;
        end else if (doorbell && state != ST_IDLE) begin
            db_pend_nx = 1'b1;
        end
        unique case (state)
            ST_IDLE: if (doorbell) state_nx = ST_REQ;
            ST_REQ:  state_nx = ST_WAIT;
            ST_WAIT: begin
                if (resp_here) begin
                    if (owned || db_pend || doorbell) state_nx = ST_REQ;
                    else                               state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            db_pend <= 1'b0;
        end else begin
            state   <= state_nx;
            db_pend <= db_pend_nx;
        end
    end

    // outputs
    always_comb begin
        rd_req = (state == ST_REQ);
        step   = resp_here && owned && !is_link;
        jump   = resp_here && owned && is_link;
        flip   = jump && flip_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= 1'b0;
            ent_addr  <= '0;
            ent_data  <= '0;
        end else begin
            ent_valid <= step;
            if (step) begin
                ent_addr <= deq_addr;
                ent_data <= rsp_entry;
            end
        end
    end
endmodule

// File: rtl/ring_fetch_engine.sv
module ring_fetch_engine
    import ring_fetch_pkg::*;
#(
    parameter int                ADDR_W    = 64,
    parameter logic [ADDR_W-1:0] RING_BASE = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rd_data,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_addr,
    output logic [ENT_W-1:0]  ent_data
);
    logic              owned, is_link, flip_req;
    logic [ADDR_W-1:0] link_target;
    logic              step, jump, flip;
    logic [ADDR_W-1:0] deq_addr;
    logic              cyc_state;

    ring_entry_decode #(.ADDR_W(ADDR_W)) dec_i (
        .cyc_bit     (mem_rd_data[CYC_BIT]),
        .tog_bit     (mem_rd_data[TOG_BIT]),
        .type_f      (mem_rd_data[TYPE_LSB +: TYPE_W]),
        .link_field  (mem_rd_data[ADDR_W-1:0]),
        .cyc_state   (cyc_state),
        .owned       (owned),
        .is_link     (is_link),
        .flip_req    (flip_req),
        .link_target (link_target)
    );

    ring_deq_ptr #(.ADDR_W(ADDR_W), .RING_BASE(RING_BASE)) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .jump      (jump),
        .jump_addr (link_target),
        .flip      (flip),
        .deq_addr  (deq_addr),
        .cyc_state (cyc_state)
    );

    ring_fetch_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .doorbell  (doorbell),
        .rsp_valid (mem_rd_rsp_valid),
        .rsp_entry (mem_rd_data),
        .owned     (owned),
        .is_link   (is_link),
        .flip_req  (flip_req),
        .deq_addr  (deq_addr),
        .rd_req    (mem_rd_req),
        .step      (step),
        .jump      (jump),
        .flip      (flip),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    assign mem_rd_addr = deq_addr;
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk
    import ring_fetch_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              doorbell,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_rsp_valid,
    input logic              ent_valid,
    input logic [ADDR_W-1:0] ent_addr,
    input logic [ENT_W-1:0]  ent_data
);
    logic seen_db;
    logic in_flight;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_db   <= 1'b0;
            in_flight <= 1'b0;
        end else begin
            if (doorbell) seen_db <= 1'b1;
            if (mem_rd_req)            in_flight <= 1'b1;
            else if (mem_rd_rsp_valid) in_flight <= 1'b0;
        end
    end

    assert_idle_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_rd_req && !ent_valid);

    assert_req_needs_db_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> seen_db);

    assert_out_after_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> $past(mem_rd_rsp_valid));

    assert_out_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> ent_addr[3:0] == 4'h0);

    assert_no_link_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> ent_data[TYPE_LSB +: TYPE_W] != LINK_CODE);

    assert_rd_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[3:0] == 4'h0);

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !in_flight);
endmodule

bind ring_fetch_engine ring_fetch_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .doorbell         (doorbell),
    .mem_rd_req       (mem_rd_req),
    .mem_rd_addr      (mem_rd_addr),
    .mem_rd_rsp_valid (mem_rd_rsp_valid),
    .ent_valid        (ent_valid),
    .ent_addr         (ent_addr),
    .ent_data         (ent_data)
);

// File: tb/ring_fetch_engine_tb_top.sv
`timescale 1ns/1ps
module ring_fetch_engine_tb_top;
    localparam logic [63:0] BASE = 64'h1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         doorbell = 1'b0;
    logic         mem_rd_req;
    logic [63:0]  mem_rd_addr;
    logic         mem_rd_rsp_valid = 1'b0;
    logic [127:0] mem_rd_data = '0;
    logic         ent_valid;
    logic [63:0]  ent_addr;
    logic [127:0] ent_data;

    always #2 clk = ~clk;

    ring_fetch_engine #(.ADDR_W(64), .RING_BASE(64'h1000)) dut_i (
        .clk(clk), .rst_n(rst_n), .doorbell(doorbell),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_data(mem_rd_data),
        .ent_valid(ent_valid), .ent_addr(ent_addr), .ent_data(ent_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    // memory model
    logic [127:0] mem [0:63];
    int           lat = 1;
    logic         m_pend = 1'b0;
    int           m_cnt = 0;
    logic [127:0] m_hold = '0;

    function automatic int idx_of(input logic [63:0] a);
        logic [63:0] d;
        d = (a - BASE) >> 4;
        return int'(d[5:0]);
    endfunction

    always @(posedge clk) begin
        mem_rd_rsp_valid <= 1'b0;
        if (mem_rd_req) begin
            m_hold <= mem[idx_of(mem_rd_addr)];
            m_cnt  <= lat;
            m_pend <= 1'b1;
        end else if (m_pend) begin
            if (m_cnt == 0) begin
                mem_rd_rsp_valid <= 1'b1;
                mem_rd_data      <= m_hold;
                m_pend           <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    // monitors
    logic [63:0]  got_a [$];
    logic [127:0] got_d [$];
    logic [63:0]  exp_a [$];
    logic [127:0] exp_d [$];
    int           n_rd = 0;
    logic [63:0]  rd_log [$];

    always @(negedge clk) begin
        if (ent_valid) begin
            got_a.push_back(ent_addr);
            got_d.push_back(ent_data);
        end
        if (mem_rd_req) begin
            n_rd++;
            rd_log.push_back(mem_rd_addr);
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_ent(input logic [63:0] a, input logic [31:0] st,
                                            input logic [5:0] ty, input bit tog, input bit cyc);
        logic [31:0] fl;
        fl = {16'h0, ty, 8'h0, tog, cyc};
        fl[31:16] = 16'($urandom);
        return {fl, st, a};
    endfunction

    task automatic ring_db();
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
    endtask

    task automatic settle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
        rd_log.delete(); n_rd = 0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic cmp_stream(input string req);
        check(got_a.size() == exp_a.size(), req, 128'(got_a.size()), 128'(exp_a.size()));
        for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
            check(got_a[i] == exp_a[i], req, 128'(got_a[i]), 128'(exp_a[i]));
            check(got_d[i] == exp_d[i], req, got_d[i], exp_d[i]);
        end
        got_a.delete(); got_d.delete(); exp_a.delete(); exp_d.delete();
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_mem();
        settle(4);
        // R1: outputs quiet in and right after reset
        check(!mem_rd_req && !ent_valid, "R1 reset outputs", {mem_rd_req, ent_valid}, 0);
        rst_n = 1'b1;
        settle(1);
        check(mem_rd_addr == BASE, "R1 dequeue at base", mem_rd_addr, BASE);

        // R2: no doorbell, no read
        settle(20);
        check(n_rd == 0, "R2 no read without doorbell", n_rd, 0);

        // R4: empty ring read once, then resumed at same address; R1 cycle state 1
        lat = 2;
        ring_db(); settle(12);
        check(n_rd == 1, "R4 one read on empty ring", n_rd, 1);
        check(rd_log[0] == BASE, "R2 read at dequeue address", rd_log[0], BASE);
        check(got_a.size() == 0, "R4 nothing forwarded", got_a.size(), 0);
        mem[0] = mk_ent(64'hABCD, 32'h55, 6'd1, 1'b0, 1'b1);
        exp_a.push_back(BASE); exp_d.push_back(mem[0]);
        ring_db(); settle(20);
        check(rd_log[1] == BASE, "R4 resumed at same address", rd_log[1], BASE);
        check(rd_log[2] == BASE + 16, "R3 next read plus 16", rd_log[2], BASE + 16);
        cmp_stream("R1 R3 R7 first pass owned on cycle 1");

        // R5/R6: link without toggle to target with low bits set
        do_reset(); clear_mem();
        mem[0] = mk_ent(64'h1, 32'h1, 6'd2, 1'b1, 1'b1);
        mem[1] = mk_ent(BASE + 64'h105, 32'h0, 6'd6, 1'b0, 1'b1);
        mem[16] = mk_ent(64'h77, 32'h9, 6'd3, 1'b0, 1'b1);
        exp_a.push_back(BASE); exp_d.push_back(mem[0]);
        exp_a.push_back(BASE + 64'h100); exp_d.push_back(mem[16]);
        ring_db(); settle(40);
        cmp_stream("R5 R6 link jump without toggle");
        mem[17] = mk_ent(64'h88, 32'h2, 6'd4, 1'b0, 1'b1);
        exp_a.push_back(BASE + 64'h110); exp_d.push_back(mem[17]);
        ring_db(); settle(30);
        cmp_stream("R6 cycle kept after non-toggling link");

        // R8: doorbells during a slow read collapse into one recheck
        do_reset(); clear_mem();
        lat = 6;
        ring_db();
        @(posedge clk); @(negedge clk);
        mem[0] = mk_ent(64'h42, 32'h3, 6'd1, 1'b0, 1'b1);
        doorbell = 1'b1; @(negedge clk); doorbell = 1'b0;
        @(negedge clk); doorbell = 1'b1; @(negedge clk); doorbell = 1'b0;
        exp_a.push_back(BASE); exp_d.push_back(mem[0]);
        settle(60);
        check(n_rd == 3, "R8 one recheck for several doorbells", n_rd, 3);
        cmp_stream("R8 entry written during run is picked up");

        // random rings with toggling link (R3 R6 R7)
        for (int cfg = 0; cfg < 4; cfg++) begin
            int n, pos;
            bit pcyc;
            do_reset(); clear_mem();
            n = $urandom_range(4, 12);
            mem[n-1] = mk_ent(BASE + 64'($urandom_range(0, 15)), 32'h0, 6'd6, 1'b1, 1'b0);
            pos = 0; pcyc = 1'b1;
            for (int rnd = 0; rnd < 10; rnd++) begin
                int k;
                lat = $urandom_range(0, 4);
                k = $urandom_range(0, n - 2);
                for (int e = 0; e < k; e++) begin
                    logic [5:0] ty;
                    ty = 6'($urandom_range(1, 5));
                    mem[pos] = mk_ent({$urandom, $urandom}, $urandom, ty,
                                      1'($urandom), pcyc);
                    exp_a.push_back(BASE + 64'(pos * 16)); exp_d.push_back(mem[pos]);
                    pos++;
                    if (pos == n - 1) begin
                        mem[n-1][96] = pcyc;
                        pcyc = ~pcyc;
                        pos = 0;
                    end
                end
                ring_db();
                settle(12 * (k + 3));
                cmp_stream("R3 R6 R7 random ring pass");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule